// File: doc/BRIEF.md
# PLL Rate Rounding and Multiplier Unit

This block works out what an integer-multiply PLL can actually produce for a requested output frequency. A request and the frequency of the reference feeding the PLL arrive as unsigned integers. The block first limits the request to a window set by two parameters. It then rounds the result up to the next whole multiple of the reference. If that multiple lies above the upper limit, the block takes it one reference step lower. The outputs are the achievable rate, the integer multiplier that gives it, and a bit that selects the high or low oscillator band against a third threshold parameter.

The rounding division runs on a restoring shift-subtract divider that resolves one quotient bit per clock. A second command skips the divider. It multiplies the multiplier kept from the last rounding command by the reference it is given now, and reports that as the output rate. Work starts with a single-cycle `start_i`. The block raises `done_o` for one cycle when every registered output holds its new value. A reference of zero never reaches the divider: it raises an error flag and gives zero results.

Top module: `pll_rate_calc`

## Requirements
- R1: In a rounding command (`recalc_i`=0), a request below MIN_RATE is treated as MIN_RATE, and a request above MAX_RATE is treated as MAX_RATE.
- R2: In a rounding command with a nonzero reference, `rate_o` is the smallest multiple of the reference that is at or above the limited request, unless R3 applies.
- R3: When that multiple is above MAX_RATE, `rate_o` is one reference step smaller. After a rounding command, `rate_o` never exceeds MAX_RATE.
- R4: After a rounding command, `lmul_o` equals `rate_o` divided by the reference with truncation, and the block keeps that value as the stored multiplier.
- R5: After a rounding command, `vco_hi_o` is 0 when `rate_o` is at or below LOWVCO_MAX and 1 when it is above.
- R6: A reference of zero sets `err_o`=1 and `rate_o`=0 and finishes in one cycle. In a rounding command it also clears the stored multiplier, `lmul_o` and `vco_hi_o`. Any command with a nonzero reference clears `err_o`.
- R7: A recalculation command (`recalc_i`=1) sets `rate_o` to the stored multiplier times the reference, at full 2W-bit width, and leaves `lmul_o` and `vco_hi_o` unchanged.
- R8: `done_o` is high for exactly one cycle per accepted command. `busy_o` is high while the divider runs. A `start_i` that arrives while `busy_o` is high is ignored, along with the inputs that come with it: it neither changes the result nor starts another command.
- R9: A rounding command with a nonzero reference raises `done_o` W+1 clock edges after the edge that samples `start_i`. A recalculation command, or any command with a zero reference, raises `done_o` on the sampling edge itself.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `rate_o`, `lmul_o` and `vco_hi_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a command when the block is idle |
| recalc_i | input | 1 | 0 = round the request, 1 = recompute the rate from the stored multiplier |
| req_rate_i | input | W | Requested output rate |
| ref_rate_i | input | W | Reference (parent) rate |
| busy_o | output | 1 | Divider in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command had a zero reference |
| rate_o | output | 2W | Achievable or recomputed rate |
| lmul_o | output | W | Integer multiplier |
| vco_hi_o | output | 1 | High oscillator band selected |

## Verification
The bench builds the block with W=16, MIN_RATE=1000, MAX_RATE=50000 and LOWVCO_MAX=20000. These values let 16-bit random requests land on both sides of both limits. With references above MAX_RATE, the step-back can go all the way to a rate and multiplier of zero. The band threshold falls mid-range, so exact multiples at 20000 and just above it can be hit directly. The 17-cycle divider keeps each command short enough for several hundred random commands to run next to the directed corner cases.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  typedef enum logic {
    CMD_ROUND  = 1'b0,
    CMD_RECALC = 1'b1
  } cmd_e;
endpackage

// File: rtl/pll_rate_clamp.sv
module pll_rate_clamp #(
  parameter int unsigned W        = 32,
  parameter int unsigned MIN_RATE = 100,
  parameter int unsigned MAX_RATE = 2000000000
) (
  input  logic [W-1:0] rate_i,
  output logic [W-1:0] rate_o
);
  localparam logic [W-1:0] LO_V = W'(MIN_RATE);
  localparam logic [W-1:0] HI_V = W'(MAX_RATE);

  always_comb begin
    if (rate_i < LO_V)      rate_o = LO_V;
    else if (rate_i > HI_V) rate_o = HI_V;
    else                    rate_o = rate_i;
  end
endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_n, rem_q, rem_n, dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n, done_q, done_n;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign fits  = trial >= {1'b0, dvs_q};

  always_comb begin
    quo_n  = quo_q;
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (start_i && !run_q) begin
      quo_n = dvd_i;
      rem_n = '0;
      dvs_n = dvs_i;
      cnt_n = CW'(W);
      run_n = 1'b1;
    end else if (run_q) begin
      rem_n = fits ? W'(trial - {1'b0, dvs_q}) : W'(trial);
      quo_n = {quo_q[W-2:0], fits};
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;
endmodule

// File: rtl/pll_rate_finish.sv
module pll_rate_finish #(
  parameter int unsigned W          = 32,
  parameter int unsigned MAX_RATE   = 2000000000,
  parameter int unsigned LOWVCO_MAX = 1000000000
) (
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] ref_i,
  output logic [W-1:0] rate_o,
  output logic [W-1:0] lmul_o,
  output logic         vco_hi_o
);
  localparam int unsigned PW = 2 * W + 1;
  localparam logic [PW-1:0] MAX_P = PW'(MAX_RATE);
  localparam logic [PW-1:0] LOW_P = PW'(LOWVCO_MAX);

  logic [W:0]    q_up, l_full;
  logic [PW-1:0] prod, rate_full;
  logic          over;

  always_comb begin
    q_up      = {1'b0, quo_i} + {{W{1'b0}}, (rem_i != '0)};
    prod      = PW'(q_up) * PW'(ref_i);
    over      = prod > MAX_P;
    rate_full = over ? (prod - PW'(ref_i)) : prod;
    l_full    = over ? (q_up - 1'b1) : q_up;
    rate_o    = W'(rate_full);
    lmul_o    = W'(l_full);
    vco_hi_o  = rate_full > LOW_P;
  end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_rate_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned MIN_RATE   = 100,
  parameter int unsigned MAX_RATE   = 2000000000,
  parameter int unsigned LOWVCO_MAX = 1000000000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           recalc_i,
  input  logic [W-1:0]   req_rate_i,
  input  logic [W-1:0]   ref_rate_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [2*W-1:0] rate_o,
  output logic [W-1:0]   lmul_o,
  output logic           vco_hi_o
);
  localparam int unsigned RW = 2 * W;

  if (MIN_RATE > MAX_RATE) begin : g_bad_limits
    $error("pll_rate_calc: MIN_RATE must not exceed MAX_RATE");
  end

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cmd_e          cmd;
  logic [W-1:0]  clamped, quo, rem, fin_rate, fin_l;
  logic          fin_vco, div_done, div_go;
  logic          busy_q, busy_n, done_q, done_n, err_q, err_n, vco_q, vco_n;
  logic [W-1:0]  ref_q, ref_n, l_q, l_n;
  logic [RW-1:0] rate_q, rate_n;

  assign cmd = cmd_e'(recalc_i);

  pll_rate_clamp #(.W(W), .MIN_RATE(MIN_RATE), .MAX_RATE(MAX_RATE)) clamp_i (
    .rate_i (req_rate_i),
    .rate_o (clamped)
  );

  pll_seq_div #(.W(W)) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (div_go),
    .dvd_i   (clamped),
    .dvs_i   (ref_rate_i),
    .quo_o   (quo),
    .rem_o   (rem),
    .done_o  (div_done)
  );

  pll_rate_finish #(.W(W), .MAX_RATE(MAX_RATE), .LOWVCO_MAX(LOWVCO_MAX)) fin_i (
    .quo_i    (quo),
    .rem_i    (rem),
    .ref_i    (ref_q),
    .rate_o   (fin_rate),
    .lmul_o   (fin_l),
    .vco_hi_o (fin_vco)
  );

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    err_n  = err_q;
    rate_n = rate_q;
    l_n    = l_q;
    vco_n  = vco_q;
    ref_n  = ref_q;
    div_go = 1'b0;
    if (!busy_q && start_i) begin
      if (ref_rate_i == '0) begin
        done_n = 1'b1;
        err_n  = 1'b1;
        rate_n = '0;
        if (cmd == CMD_ROUND) begin
          l_n   = '0;
          vco_n = 1'b0;
        end
      end else if (cmd == CMD_RECALC) begin
        done_n = 1'b1;
        err_n  = 1'b0;
        rate_n = RW'(l_q) * RW'(ref_rate_i);
      end else begin
        busy_n = 1'b1;
        ref_n  = ref_rate_i;
        div_go = 1'b1;
      end
    end else if (busy_q && div_done) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      err_n  = 1'b0;
      rate_n = RW'(fin_rate);
      l_n    = fin_l;
      vco_n  = fin_vco;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rate_q <= '0;
      l_q    <= '0;
      vco_q  <= 1'b0;
      ref_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      err_q  <= err_n;
      rate_q <= rate_n;
      l_q    <= l_n;
      vco_q  <= vco_n;
      ref_q  <= ref_n;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign rate_o   = rate_q;
  assign lmul_o   = l_q;
  assign vco_hi_o = vco_q;
endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
  parameter int unsigned W          = 32,
  parameter int unsigned MAX_RATE   = 2000000000,
  parameter int unsigned LOWVCO_MAX = 1000000000
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           recalc_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o,
  input logic [2*W-1:0] rate_o,
  input logic           vco_hi_o
);
  localparam logic [2*W-1:0] MAX_C = (2*W)'(MAX_RATE);
  localparam logic [2*W-1:0] LOW_C = (2*W)'(LOWVCO_MAX);

  logic last_round_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_round_q <= 1'b0;
    else if (start_i && !busy_o) last_round_q <= !recalc_i;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R6
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rate_o == '0));

  // R3
  rate_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && last_round_q && !err_o) |-> (rate_o <= MAX_C));

  // R5
  vco_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && last_round_q && !err_o) |-> (vco_hi_o == (rate_o > LOW_C)));
endmodule

bind pll_rate_calc pll_rate_calc_chk #(
  .W(W), .MAX_RATE(MAX_RATE), .LOWVCO_MAX(LOWVCO_MAX)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .recalc_i (recalc_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .rate_o   (rate_o),
  .vco_hi_o (vco_hi_o)
);

// File: tb/pll_rate_calc_tb_top.sv
`timescale 1ns/1ps
module pll_rate_calc_tb_top;
  localparam int unsigned W    = 16;
  localparam int unsigned MINR = 1000;
  localparam int unsigned MAXR = 50000;
  localparam int unsigned LOWR = 20000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           recalc = 1'b0;
  logic [W-1:0]   req = '0;
  logic [W-1:0]   refr = '0;
  logic           busy, done, err, vco;
  logic [2*W-1:0] rate;
  logic [W-1:0]   lmul;

  int n_chk = 0;
  int n_bad = 0;
  longint model_l = 0;
  bit model_vco = 1'b0;

  always #2 clk = ~clk;

  pll_rate_calc #(.W(W), .MIN_RATE(MINR), .MAX_RATE(MAXR), .LOWVCO_MAX(LOWR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .recalc_i(recalc),
    .req_rate_i(req), .ref_rate_i(refr), .busy_o(busy), .done_o(done),
    .err_o(err), .rate_o(rate), .lmul_o(lmul), .vco_hi_o(vco));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint round_rate(longint rq, longint rf);
    longint c, q, r;
    c = (rq < MINR) ? MINR : ((rq > MAXR) ? MAXR : rq);
    q = (c + rf - 1) / rf;
    r = q * rf;
    if (r > MAXR) r = r - rf;
    return r;
  endfunction

  task automatic run_op(input bit rc, input int unsigned rq, input int unsigned rf, input bit poke);
    int n;
    longint er, el;
    bit ee, ev;
    int elat;
    @(negedge clk);
    recalc = rc; req = W'(rq); refr = W'(rf); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 60) begin
      if (poke && n == 2) begin
        start = 1'b1; recalc = ~rc; req = W'(rq ^ 32'h5a5a); refr = 16'h0101;
      end else if (poke && n == 3) begin
        start = 1'b0;
      end
      if (n == 4) check(busy == 1'b1, "R8 busy while dividing", busy, 1);
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    if (rf == 0) begin
      ee = 1'b1; er = 0; elat = 0;
      if (!rc) begin model_l = 0; model_vco = 1'b0; end
    end else if (rc) begin
      ee = 1'b0; er = model_l * rf; elat = 0;
    end else begin
      ee = 1'b0; er = round_rate(rq, rf); elat = W + 1;
      model_l = er / rf; model_vco = (er > LOWR);
    end
    el = model_l; ev = model_vco;
    check(n == elat, "R9 done latency", n, elat);
    check(err == ee, "R6 error flag", err, ee);
    check(longint'(rate) == er, rc ? "R7 recomputed rate" : "R2/R3 rounded rate", rate, er);
    check(longint'(lmul) == el, rc ? "R7 multiplier held" : "R4 multiplier", lmul, el);
    check(vco == ev, rc ? "R7 band held" : "R5 band select", vco, ev);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8 single-cycle done", done, 0);
    if (poke) check(busy == 1'b0, "R8 poke started nothing", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0 && err == 0, "R10 flags in reset", {busy, done, err}, 0);
    check(rate == 0 && lmul == 0 && vco == 0, "R10 data in reset", rate, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0 && rate == 0, "R10 after release", rate, 0);

    run_op(1'b0, 10, 300, 1'b0);      // R1 low clamp: 1200, L=4
    run_op(1'b0, 60000, 7000, 1'b0);  // R1 high clamp, R3 step back: 49000, L=7
    run_op(1'b0, 21000, 3000, 1'b0);  // R2 exact multiple, R5 above
    run_op(1'b0, 20000, 4000, 1'b0);  // R5 at threshold -> 0
    run_op(1'b0, 20001, 1, 1'b0);     // R5 just above
    run_op(1'b1, 0, 3, 1'b0);         // R7 20001*3
    run_op(1'b0, 5000, 60000, 1'b0);  // R3 step back to zero
    run_op(1'b0, 12345, 0, 1'b0);     // R6 zero reference, round
    run_op(1'b0, 33333, 777, 1'b1);   // R8 start ignored while busy
    run_op(1'b1, 0, 0, 1'b0);         // R6 zero reference, recalc
    run_op(1'b1, 0, 65535, 1'b0);     // R7 full-width product

    for (int i = 0; i < 400; i++) begin
      int unsigned rq, rf, sel;
      bit rc;
      rq  = $urandom() & 32'hffff;
      sel = $urandom() % 50;
      if (sel == 0)      rf = 0;
      else if (sel < 20) rf = 1 + ($urandom() % 300);
      else               rf = 1 + ($urandom() % 65535);
      rc = (($urandom() % 4) == 0);
      run_op(rc, rq, rf, (i % 17) == 5);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule